// File: doc/BRIEF.md
# Programmable Bus Transaction Trigger

This block sits beside one bus master's wrapper and watches a simplified view of its traffic: a valid strobe, a read/write flag, an address and the identity of the requesting master. It compares each transfer against a small program of up to four ordered stages. A stage selects read requests, write requests or both. It selects an address window through a base value and a compare mask, and it can optionally require one master identity. When every stage has matched in order, the block emits a one-cycle trigger. The trigger carries the type, address and master identity of the final transfer. A timestamp and trace-capture stage downstream uses this trigger to record the event.

The stage program, the number of active stages and a timeout are loaded through a simple write-only configuration port. While the trigger is armed, this program is frozen. A test harness can reprogram it between runs by clearing the enable bit, rewriting the stages and arming it again. If the sequence has advanced past its first stage and the next stage then fails to match within a programmable number of bus transfers, the sequence falls back to the first stage.

Top module: `bus_trig_top`

## Requirements
- R1: After synchronous reset, trig_pulse, trig_write, trig_addr and trig_mid are all zero and the trigger is disarmed.
- R2: Bits 1:0 of a stage control word are a type mask, with bit 0 accepting reads (bus_write=0) and bit 1 accepting writes (bus_write=1); a transfer whose type bit is clear does not match that stage.
- R3: A stage matches an address only when ((bus_addr XOR base) AND mask) is zero, with base at stage offset 1 and mask at stage offset 2.
- R4: When bit 4 of a stage control word is set, the stage matches only transfers whose bus_mid equals bits 11:8 of that word; when bit 4 is clear, any master identity matches.
- R5: Stages are matched strictly in order, starting from stage 0 and ending at the last stage index held in bits 2:1 of the control register at address 0; the trigger fires on the transfer that matches the last stage.
- R6: A transfer that does not match the current stage does not advance the sequence; after a firing, the sequence restarts at stage 0.
- R7: With a nonzero timeout value T (register at address 1), T consecutive non-matching transfers at a stage above 0 return the sequence to stage 0; a value of 0 disables the timeout.
- R8: While the enable bit (bit 0 at address 0) is set, writes to the stage registers, the timeout register and the stage-count field are ignored; only the enable bit can be changed.
- R9: While disarmed, no trigger fires, and clearing the enable bit discards any partial sequence progress.
- R10: trig_pulse is high for the single cycle after the clock edge that samples the final matching transfer; trig_write, trig_addr and trig_mid then show that transfer's type, address and identity, and hold them until the next firing.
- R11: Cycles with bus_valid low neither match a stage nor count toward the timeout.

Stage s (0 to 3) occupies configuration addresses 4+4s (control word), 5+4s (base) and 6+4s (mask).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | Transfer present on the wrapper this cycle |
| bus_write | input | 1 | 1 for a write request, 0 for a read request |
| bus_addr | input | 32 | Transfer address |
| bus_mid | input | 4 | Identity of the requesting master |
| trig_pulse | output | 1 | One-cycle trigger |
| trig_write | output | 1 | Type of the transfer that fired the trigger |
| trig_addr | output | 32 | Address of the transfer that fired the trigger |
| trig_mid | output | 4 | Master identity of the transfer that fired the trigger |

## Verification
The two-stage program is driven with transfers that differ in only one field from a matching one: wrong type, an address just outside the masked window, or a wrong master identity. Each of these shows that its own comparison is decisive. Runs of idle cycles and runs of non-matching transfers placed between the stages separate the timeout counter from plain elapsed time. Single-stage programs with different type masks check the type select, the pulse width and the captured fields. Reprogramming attempts while armed, and a disarm made in the middle of a sequence, show that a frozen program and discarded progress can be told apart from a live one.

// File: rtl/bus_trig_pkg.sv
package bus_trig_pkg;

    localparam int ADDR_W     = 32;
    localparam int MID_W      = 4;
    localparam int MAX_STAGES = 4;
    localparam int TMO_W      = 16;
    localparam int STG_W      = $clog2(MAX_STAGES);
    localparam int CFG_DW     = ADDR_W;
    localparam int CFG_AW     = $clog2(4 * (MAX_STAGES + 1));

    // register offsets inside a stage block and of the global registers
    localparam int OFS_CTL  = 0;
    localparam int OFS_BASE = 1;
    localparam int OFS_MASK = 2;
    localparam int REG_CTRL = 0;
    localparam int REG_TMO  = 1;

    // field positions in a stage control word
    localparam int KIND_LSB  = 0;
    localparam int IDCHK_BIT = 4;
    localparam int ID_LSB    = 8;

    typedef enum logic [0:0] {
        XFER_RD = 1'b0,
        XFER_WR = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        logic [1:0]        kind_mask;
        logic              id_chk;
        logic [MID_W-1:0]  id;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } stage_cfg_t;

    typedef struct packed {
        logic              valid;
        xfer_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [MID_W-1:0]  mid;
    } xfer_t;

    function automatic logic [CFG_AW-1:0] stage_reg(input int stg, input int ofs);
        return CFG_AW'(4 * (stg + 1) + ofs);
    endfunction

    function automatic logic stage_hit(input stage_cfg_t c, input xfer_t x);
        logic kind_ok, addr_ok, id_ok;
        kind_ok = c.kind_mask[x.kind];
        addr_ok = ((x.addr ^ c.base) & c.mask) == '0;
        id_ok   = !c.id_chk || (c.id == x.mid);
        return x.valid && kind_ok && addr_ok && id_ok;
    endfunction

endpackage

// File: rtl/bt_cfg_regs.sv
module bt_cfg_regs
    import bus_trig_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    output logic                   arm,
    output logic [STG_W-1:0]       last_stage,
    output logic [TMO_W-1:0]       tmo_limit,
    output stage_cfg_t [MAX_STAGES-1:0] stages
);

    logic unlocked_wr;
    assign unlocked_wr = cfg_we && !arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm        <= 1'b0;
            last_stage <= '0;
            tmo_limit  <= '0;
        end else begin
            if (cfg_we && cfg_addr == CFG_AW'(REG_CTRL)) begin
                arm <= cfg_wdata[0];
                if (!arm) last_stage <= cfg_wdata[1 +: STG_W];
            end
            if (unlocked_wr && cfg_addr == CFG_AW'(REG_TMO))
                tmo_limit <= cfg_wdata[TMO_W-1:0];
        end
    end

    for (genvar s = 0; s < MAX_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stages[s] <= '0;
            end else if (unlocked_wr) begin
                if (cfg_addr == stage_reg(s, OFS_CTL)) begin
                    stages[s].kind_mask <= cfg_wdata[KIND_LSB +: 2];
                    stages[s].id_chk    <= cfg_wdata[IDCHK_BIT];
                    stages[s].id        <= cfg_wdata[ID_LSB +: MID_W];
                end
                if (cfg_addr == stage_reg(s, OFS_BASE))
                    stages[s].base <= cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == stage_reg(s, OFS_MASK))
                    stages[s].mask <= cfg_wdata[ADDR_W-1:0];
            end
        end
    end

    // R8: the stage program and timeout stay frozen across a write made while armed
    p_frozen_program_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && arm) |=> ($stable(stages) && $stable(tmo_limit) && $stable(last_stage)));

endmodule

// File: rtl/bt_stage_match.sv
module bt_stage_match
    import bus_trig_pkg::*;
(
    input  stage_cfg_t [MAX_STAGES-1:0] stages,
    input  xfer_t                       xfer,
    output logic [MAX_STAGES-1:0]       hit
);

    for (genvar s = 0; s < MAX_STAGES; s++) begin : g_cmp
        assign hit[s] = stage_hit(stages[s], xfer);
    end

    // R11: an idle bus cycle never produces a stage hit
    always_comb begin
        if (!xfer.valid) p_idle_no_hit_r11: assert (hit == '0);
    end

endmodule

// File: rtl/bt_seq_fsm.sv
module bt_seq_fsm
    import bus_trig_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm,
    input  logic [STG_W-1:0]      last_stage,
    input  logic [TMO_W-1:0]      tmo_limit,
    input  logic [MAX_STAGES-1:0] hit,
    input  xfer_t                 xfer,
    output logic                  fire,
    output xfer_t                 fired
);

    logic [STG_W-1:0] stage_q;
    logic [TMO_W-1:0] miss_q;
    logic [TMO_W:0]   miss_nx;
    logic             cur_hit;
    logic             expire;

    assign cur_hit = hit[stage_q];
    assign miss_nx = {1'b0, miss_q} + 1'b1;
    assign expire  = miss_nx >= {1'b0, tmo_limit};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            miss_q  <= '0;
            fire    <= 1'b0;
            fired   <= '0;
        end else begin
            fire <= 1'b0;
            if (!arm) begin
                stage_q <= '0;
                miss_q  <= '0;
            end else if (xfer.valid) begin
                if (cur_hit) begin
                    miss_q <= '0;
                    if (stage_q == last_stage) begin
                        fire    <= 1'b1;
                        fired   <= xfer;
                        stage_q <= '0;
                    end else begin
                        stage_q <= stage_q + 1'b1;
                    end
                end else if (stage_q != '0 && tmo_limit != '0) begin
                    if (expire) begin
                        stage_q <= '0;
                        miss_q  <= '0;
                    end else begin
                        miss_q <= miss_nx[TMO_W-1:0];
                    end
                end
            end
        end
    end

    // R7: the miss counter is only live away from stage 0 and stays below the limit
    p_idle_count_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (stage_q == '0) |-> (miss_q == '0));
    p_count_below_limit_r7: assert property (@(posedge clk) disable iff (rst)
        (miss_q != '0) |-> (miss_q < tmo_limit));
    // R9: disarming always returns to stage 0
    p_disarm_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (stage_q == '0));
    // R5: progress never passes the programmed last stage
    p_stage_bound_r5: assert property (@(posedge clk) disable iff (rst)
        stage_q <= last_stage);
    // R10: a pulse follows an armed, valid transfer one edge earlier
    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(fire) |-> $past(arm && xfer.valid));

endmodule

// File: rtl/bus_trig_top.sv
module bus_trig_top
    import bus_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [MID_W-1:0]  bus_mid,
    output logic              trig_pulse,
    output logic              trig_write,
    output logic [ADDR_W-1:0] trig_addr,
    output logic [MID_W-1:0]  trig_mid
);

    logic                        arm;
    logic [STG_W-1:0]            last_stage;
    logic [TMO_W-1:0]            tmo_limit;
    stage_cfg_t [MAX_STAGES-1:0] stages;
    logic [MAX_STAGES-1:0]       hit;
    xfer_t                       xfer;
    xfer_t                       fired;

    assign xfer.valid = bus_valid;
    assign xfer.kind  = xfer_kind_e'(bus_write);
    assign xfer.addr  = bus_addr;
    assign xfer.mid   = bus_mid;

    bt_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .arm        (arm),
        .last_stage (last_stage),
        .tmo_limit  (tmo_limit),
        .stages     (stages)
    );

    bt_stage_match u_match (
        .stages (stages),
        .xfer   (xfer),
        .hit    (hit)
    );

    bt_seq_fsm u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .last_stage (last_stage),
        .tmo_limit  (tmo_limit),
        .hit        (hit),
        .xfer       (xfer),
        .fire       (trig_pulse),
        .fired      (fired)
    );

    assign trig_write = fired.kind == XFER_WR;
    assign trig_addr  = fired.addr;
    assign trig_mid   = fired.mid;

    // R9: a disarmed block stays silent on the following edge
    p_silent_disarmed_r9: assert property (@(posedge clk) disable iff (rst)
        (!arm) |=> !trig_pulse);

endmodule

// File: tb/test_bus_trig_top.sv
module test_bus_trig_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [3:0]  bus_mid = '0;
    logic        trig_pulse;
    logic        trig_write;
    logic [31:0] trig_addr;
    logic [3:0]  trig_mid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_trig_top i_bus_trig_top (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_mid    (bus_mid),
        .trig_pulse (trig_pulse),
        .trig_write (trig_write),
        .trig_addr  (trig_addr),
        .trig_mid   (trig_mid)
    );

    // vector: {valid, write, addr[31:0], mid[3:0], expected pulse}
    localparam int NVEC = 16;
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 32'h0000_1000, 4'd0, 1'b0},  // R5 stage 0 write
        {1'b1, 1'b0, 32'h0000_2004, 4'd3, 1'b1},  // R5 stage 1 fires
        {1'b1, 1'b0, 32'h0000_2004, 4'd3, 1'b0},  // R6 restart at stage 0
        {1'b1, 1'b1, 32'h0000_1ABC, 4'd5, 1'b0},  // R3 masked window
        {1'b1, 1'b0, 32'h0000_2004, 4'd2, 1'b0},  // R4 wrong id
        {1'b1, 1'b0, 32'h0000_2010, 4'd3, 1'b1},  // R4 right id fires
        {1'b1, 1'b1, 32'h0000_1000, 4'd0, 1'b0},  // stage 0
        {1'b1, 1'b0, 32'h0000_2104, 4'd3, 1'b0},  // R3 outside window, miss 1
        {1'b1, 1'b1, 32'h0000_3000, 4'd3, 1'b0},  // R2 wrong type, miss 2 -> timeout
        {1'b1, 1'b0, 32'h0000_2000, 4'd3, 1'b0},  // R7 back at stage 0
        {1'b0, 1'b1, 32'h0000_1000, 4'd0, 1'b0},  // R11 idle
        {1'b1, 1'b1, 32'h0000_1000, 4'd0, 1'b0},  // stage 0
        {1'b0, 1'b0, 32'h0000_2104, 4'd3, 1'b0},  // R11 idle
        {1'b0, 1'b1, 32'h0000_3000, 4'd3, 1'b0},  // R11 idle
        {1'b0, 1'b0, 32'h0000_2104, 4'd1, 1'b0},  // R11 idle
        {1'b1, 1'b0, 32'h0000_2000, 4'd3, 1'b1}   // R11 idles not counted, fires
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 5'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic stage_wr(input int s, input logic [31:0] ctl,
                            input logic [31:0] base, input logic [31:0] mask);
        cfg_wr(4 + 4*s, ctl);
        cfg_wr(5 + 4*s, base);
        cfg_wr(6 + 4*s, mask);
    endtask

    // drive one cycle of bus traffic; returns the pulse seen after the sampling edge
    task automatic xfer(input logic v, input logic w, input logic [31:0] a,
                        input logic [3:0] m, output logic p);
        @(negedge clk);
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_mid   = m;
        @(posedge clk);
        #1;
        p = trig_pulse;
        bus_valid = 1'b0;
    endtask

    // two-stage program: write in 0x1xxx, then read in 0x20xx from id 3
    task automatic load_two_stage(input logic [31:0] tmo);
        cfg_wr(0, 32'h0);
        stage_wr(0, 32'h0000_0002, 32'h0000_1000, 32'hFFFF_F000);
        stage_wr(1, 32'h0000_0311, 32'h0000_2000, 32'hFFFF_FF00);
        cfg_wr(1, tmo);
        cfg_wr(0, 32'h0000_0003);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic p;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 pulse", 32'(trig_pulse), 0);
        check("R1 write", 32'(trig_write), 0);
        check("R1 addr", trig_addr, 0);
        check("R1 mid", 32'(trig_mid), 0);
        @(negedge clk);
        rst = 1'b0;

        // R9 disarmed after reset: a transfer that would match cannot fire
        stage_wr(0, 32'h0000_0003, 32'h0, 32'h0);
        xfer(1'b1, 1'b1, 32'h10, 4'd1, p);
        check("R9 disarmed after reset", 32'(p), 0);

        load_two_stage(32'd2);
        for (int i = 0; i < NVEC; i++) begin
            logic [38:0] v;
            v = VEC[i];
            xfer(v[38], v[37], v[36:5], v[4:1], p);
            check($sformatf("R5/R6 vector %0d pulse", i), 32'(p), 32'(v[0]));
            if (v[0]) begin
                check($sformatf("R10 vector %0d addr", i), trig_addr, v[36:5]);
                check($sformatf("R10 vector %0d write", i), 32'(trig_write), 32'(v[37]));
            end
        end

        // R2 single stage accepting both types, back-to-back; R10 pulse width and capture
        cfg_wr(0, 32'h0);
        stage_wr(0, 32'h0000_0003, 32'h0, 32'h0);
        cfg_wr(0, 32'h0000_0001);
        xfer(1'b1, 1'b0, 32'hCAFE_0000, 4'd7, p);
        check("R2 read accepted", 32'(p), 1);
        check("R10 write flag read", 32'(trig_write), 0);
        check("R10 mid", 32'(trig_mid), 7);
        xfer(1'b1, 1'b1, 32'hBEEF_0004, 4'd9, p);
        check("R2 write accepted", 32'(p), 1);
        check("R10 write flag write", 32'(trig_write), 1);
        check("R10 addr", trig_addr, 32'hBEEF_0004);
        xfer(1'b0, 1'b0, 32'h0, 4'd0, p);
        check("R10 single cycle", 32'(p), 0);
        check("R10 addr held", trig_addr, 32'hBEEF_0004);

        // R2 read-only mask rejects writes
        cfg_wr(0, 32'h0);
        stage_wr(0, 32'h0000_0001, 32'h0, 32'h0);
        cfg_wr(0, 32'h0000_0001);
        xfer(1'b1, 1'b1, 32'h40, 4'd0, p);
        check("R2 write rejected", 32'(p), 0);
        xfer(1'b1, 1'b0, 32'h40, 4'd0, p);
        check("R2 read accepted", 32'(p), 1);

        // R8 writes while armed leave the program alone
        stage_wr(0, 32'h0000_0002, 32'hFFFF_0000, 32'hFFFF_FFFF);
        cfg_wr(0, 32'h0000_0003);
        xfer(1'b1, 1'b0, 32'h44, 4'd0, p);
        check("R8 program unchanged", 32'(p), 1);
        xfer(1'b1, 1'b1, 32'hFFFF_0000, 4'd0, p);
        check("R8 new stage not loaded", 32'(p), 0);

        // R9 disarm in mid-sequence discards progress
        load_two_stage(32'd0);
        xfer(1'b1, 1'b1, 32'h1000, 4'd0, p);
        check("R9 stage 0", 32'(p), 0);
        cfg_wr(0, 32'h0000_0002);
        xfer(1'b1, 1'b0, 32'h2000, 4'd3, p);
        check("R9 disarmed no fire", 32'(p), 0);
        cfg_wr(0, 32'h0000_0003);
        xfer(1'b1, 1'b0, 32'h2000, 4'd3, p);
        check("R9 progress discarded", 32'(p), 0);

        // R7 timeout of 0: long miss run does not reset progress
        xfer(1'b1, 1'b1, 32'h1000, 4'd0, p);
        for (int k = 0; k < 6; k++) xfer(1'b1, 1'b1, 32'h9000, 4'd3, p);
        xfer(1'b1, 1'b0, 32'h20FC, 4'd3, p);
        check("R7 timeout disabled", 32'(p), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule